// File: doc/BRIEF.md
# Multiplexed Bus Strobe Sequencer

This block turns the oscillator clock of a small 8-bit controller into the timing of its external multiplexed bus. Every twelve oscillator periods form one machine cycle, split into six states of two phases each. In each slot of that frame the block decides whether to drive the address-latch pulse, the program-fetch read strobe, or the data read and write strobes. It also decides when the low-byte port carries an address or write data, and whether the high-byte port carries the upper address.

At each machine-cycle boundary it takes a snapshot of the program counter and of the data-memory read and write requests. From that snapshot it chooses the strobe pattern for the cycle. Fetches come from on-chip program memory only when the external-access strap was high as reset ended and the program counter is below the on-chip size. A data cycle drops the second address-latch pulse and both fetch strobes, and drives the read or write strobe in their place. The reset pin is filtered so that only a sufficiently long high level resets the sequencer.

Top module: `bus_strobe_seq`

## Requirements
- R1: `state_o` (1 to 6) and `phase_o` (0 = first phase, 1 = second phase) step through all twelve slots in order. Slot index t = 2*(state_o-1)+phase_o runs 0..11 and then wraps to 0, so one machine cycle lasts 12 clocks.
- R2: `ale_o` is high in slots 0-1 and 6-7 of every cycle that carries no data access, whatever the fetch source. That gives two pulses per cycle, each 2 clocks wide.
- R3: In a cycle flagged as a data read or write, the slot 6-7 address-latch pulse is omitted and the slot 0-1 pulse remains, so the cycle has one pulse.
- R4: `psen_o` is high in slots 3-5 and 9-11 of an external-fetch cycle with no data access, giving two 3-clock pulses. In a data cycle both pulses are omitted.
- R5: Fetch is internal, with `psen_o` never high, when the latched strap is 1 and `pc_i` < 4096. If `pc_i` >= 4096 the fetch is external.
- R6: The strap is captured on the clock edge that ends reset and then holds. A strap of 0 makes every fetch external for any `pc_i`, and moving `ea_strap` after reset has no effect.
- R7: `rd_o` or `wr_o` is high in slots 3-8 (6 clocks) of a cycle flagged with the matching request. The two strobes are never high together: if both requests are set, only the read is performed. Neither strobe overlaps `ale_o`.
- R8: `pc_i`, `dmem_rd_req` and `dmem_wr_req` are sampled only on the edge that moves from slot 11 to slot 0. Changes made inside a cycle do not alter that cycle.
- R9: Reset takes effect only after `rst_pin` has been high for 24 consecutive clocks. A 23-clock high pulse leaves the slot sequence undisturbed.
- R10: While reset is in effect, every strobe and enable is low and the frame holds at state 6, phase 1. The first slot 0 follows one clock after the pin-low edge that releases reset.
- R11: `ad_addr_oe` is high exactly while `ale_o` is high in a cycle that fetches externally or accesses data. `ad_data_oe` is high in slots 2-9 of a write cycle. `hi_addr_sel` is high for the whole cycle when the fetch is external or a data access is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, one slot per period |
| rst_pin | input | 1 | Raw reset pin, active high, filtered |
| ea_strap | input | 1 | External-access strap, captured as reset ends |
| pc_i | input | 16 | Program counter for the coming cycle |
| dmem_rd_req | input | 1 | Coming cycle reads external data memory |
| dmem_wr_req | input | 1 | Coming cycle writes external data memory |
| ale_o | output | 1 | Address-latch pulse, active high |
| psen_o | output | 1 | Program-fetch read strobe, active high |
| rd_o | output | 1 | Data read strobe, active high |
| wr_o | output | 1 | Data write strobe, active high |
| ad_addr_oe | output | 1 | Low-byte port drives address |
| ad_data_oe | output | 1 | Low-byte port drives write data |
| hi_addr_sel | output | 1 | High-byte port emits upper address |
| state_o | output | 3 | Machine-cycle state, 1 to 6 |
| phase_o | output | 1 | Phase within the state |

## Verification
The strobes are registered from the next slot and the next cycle kind, so each strobe changes on the same edge that moves the slot indicator. An input sampled at the slot-11 edge therefore shapes the strobes seen at slot 0 through slot 11 of the cycle that follows. The bench drives its inputs at the falling edge where slot 11 is visible. It then compares all outputs at each of the next twelve falling edges against a pattern computed from the slot number, and counts rising edges of the address-latch and fetch strobes over the same window. Reset timing is checked by counting falling edges after the pin rises. The frame must keep advancing through edge 23, and from edge 25 on it must be frozen.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

  localparam int TICK_W = 4;
  localparam logic [TICK_W-1:0] LAST_TICK = 4'd11;

  // slot windows of the machine-cycle frame
  localparam logic [TICK_W-1:0] ALE_A_LO  = 4'd0;
  localparam logic [TICK_W-1:0] ALE_A_HI  = 4'd1;
  localparam logic [TICK_W-1:0] ALE_B_LO  = 4'd6;
  localparam logic [TICK_W-1:0] ALE_B_HI  = 4'd7;
  localparam logic [TICK_W-1:0] PSEN_A_LO = 4'd3;
  localparam logic [TICK_W-1:0] PSEN_A_HI = 4'd5;
  localparam logic [TICK_W-1:0] PSEN_B_LO = 4'd9;
  localparam logic [TICK_W-1:0] PSEN_B_HI = 4'd11;
  localparam logic [TICK_W-1:0] DSTB_LO   = 4'd3;
  localparam logic [TICK_W-1:0] DSTB_HI   = 4'd8;
  localparam logic [TICK_W-1:0] DDRV_LO   = 4'd2;
  localparam logic [TICK_W-1:0] DDRV_HI   = 4'd9;

  typedef struct packed {
    logic ext;
    logic rd;
    logic wr;
  } cyc_kind_t;

  typedef struct packed {
    logic ale;
    logic psen;
    logic rd;
    logic wr;
    logic addr_oe;
    logic data_oe;
    logic hi_sel;
  } strobe_t;

  function automatic logic in_win(input logic [TICK_W-1:0] t,
                                  input logic [TICK_W-1:0] lo,
                                  input logic [TICK_W-1:0] hi);
    return (t >= lo) && (t <= hi);
  endfunction

  function automatic logic [2:0] state_of(input logic [TICK_W-1:0] t);
    return 3'(t >> 1) + 3'd1;
  endfunction

  function automatic strobe_t decode_slot(input logic [TICK_W-1:0] t,
                                          input cyc_kind_t k);
    strobe_t s;
    logic dat;
    dat       = k.rd | k.wr;
    s.ale     = in_win(t, ALE_A_LO, ALE_A_HI) ||
                (!dat && in_win(t, ALE_B_LO, ALE_B_HI));
    s.psen    = k.ext && !dat &&
                (in_win(t, PSEN_A_LO, PSEN_A_HI) || in_win(t, PSEN_B_LO, PSEN_B_HI));
    s.rd      = k.rd && in_win(t, DSTB_LO, DSTB_HI);
    s.wr      = k.wr && in_win(t, DSTB_LO, DSTB_HI);
    s.addr_oe = s.ale && (k.ext || dat);
    s.data_oe = k.wr && in_win(t, DDRV_LO, DDRV_HI);
    s.hi_sel  = k.ext || dat;
    return s;
  endfunction

endpackage

// File: rtl/bs_rst_filter.sv
module bs_rst_filter #(
  parameter int RST_HOLD = 24
) (
  input  logic clk,
  input  logic rst_pin,
  output logic rst_int
);
  localparam int CW = $clog2(RST_HOLD + 1);
  localparam logic [CW-1:0] LIM = CW'(RST_HOLD - 1);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (!rst_pin) begin
      run_cnt <= '0;
      rst_int <= 1'b0;
    end else begin
      if (run_cnt < LIM) run_cnt <= run_cnt + 1'b1;
      rst_int <= (run_cnt >= LIM);
    end
  end
endmodule

// File: rtl/bs_cycle_timer.sv
module bs_cycle_timer
  import bus_seq_pkg::*;
#(
  parameter int PC_W          = 16,
  parameter int INT_ROM_BYTES = 4096
) (
  input  logic                clk,
  input  logic                rst_int,
  input  logic                ea_strap,
  input  logic [PC_W-1:0]     pc_i,
  input  logic                rd_req,
  input  logic                wr_req,
  output logic [TICK_W-1:0]   tick_q,
  output logic [TICK_W-1:0]   tick_nx,
  output cyc_kind_t           kind_q,
  output cyc_kind_t           kind_nx,
  output logic                strap_q
);
  localparam logic [PC_W:0] ROM_LIM = (PC_W+1)'(INT_ROM_BYTES);

  logic      wrap;
  cyc_kind_t snap;

  assign wrap = (tick_q == LAST_TICK);

  always_comb begin
    snap.ext = !strap_q || ({1'b0, pc_i} >= ROM_LIM);
    snap.rd  = rd_req;
    snap.wr  = wr_req && !rd_req;
  end

  always_comb begin
    if (rst_int) begin
      tick_nx = LAST_TICK;
      kind_nx = '0;
    end else if (wrap) begin
      tick_nx = '0;
      kind_nx = snap;
    end else begin
      tick_nx = tick_q + 1'b1;
      kind_nx = kind_q;
    end
  end

  always_ff @(posedge clk) begin
    tick_q <= tick_nx;
    kind_q <= kind_nx;
    if (rst_int) strap_q <= ea_strap;
  end
endmodule

// File: rtl/bs_strobe_reg.sv
module bs_strobe_reg
  import bus_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_int,
  input  logic [TICK_W-1:0] tick_nx,
  input  cyc_kind_t         kind_nx,
  output strobe_t           strb_q
);
  always_ff @(posedge clk) begin
    if (rst_int) strb_q <= '0;
    else         strb_q <= decode_slot(tick_nx, kind_nx);
  end
endmodule

// File: rtl/bus_strobe_seq.sv
module bus_strobe_seq
  import bus_seq_pkg::*;
#(
  parameter int PC_W          = 16,
  parameter int INT_ROM_BYTES = 4096,
  parameter int RST_HOLD      = 24
) (
  input  logic            clk,
  input  logic            rst_pin,
  input  logic            ea_strap,
  input  logic [PC_W-1:0] pc_i,
  input  logic            dmem_rd_req,
  input  logic            dmem_wr_req,
  output logic            ale_o,
  output logic            psen_o,
  output logic            rd_o,
  output logic            wr_o,
  output logic            ad_addr_oe,
  output logic            ad_data_oe,
  output logic            hi_addr_sel,
  output logic [2:0]      state_o,
  output logic            phase_o
);
  logic              rst_int;
  logic [TICK_W-1:0] tick_q;
  logic [TICK_W-1:0] tick_nx;
  cyc_kind_t         kind_q;
  cyc_kind_t         kind_nx;
  logic              strap_q;
  strobe_t           strb_q;
  logic              ext_q;
  logic              dat_q;

  bs_rst_filter #(.RST_HOLD(RST_HOLD)) u_rst (
    .clk     (clk),
    .rst_pin (rst_pin),
    .rst_int (rst_int)
  );

  bs_cycle_timer #(.PC_W(PC_W), .INT_ROM_BYTES(INT_ROM_BYTES)) u_timer (
    .clk      (clk),
    .rst_int  (rst_int),
    .ea_strap (ea_strap),
    .pc_i     (pc_i),
    .rd_req   (dmem_rd_req),
    .wr_req   (dmem_wr_req),
    .tick_q   (tick_q),
    .tick_nx  (tick_nx),
    .kind_q   (kind_q),
    .kind_nx  (kind_nx),
    .strap_q  (strap_q)
  );

  bs_strobe_reg u_strb (
    .clk     (clk),
    .rst_int (rst_int),
    .tick_nx (tick_nx),
    .kind_nx (kind_nx),
    .strb_q  (strb_q)
  );

  // named events for the checker
  assign ext_q = kind_q.ext;
  assign dat_q = kind_q.rd | kind_q.wr;

  assign ale_o       = strb_q.ale;
  assign psen_o      = strb_q.psen;
  assign rd_o        = strb_q.rd;
  assign wr_o        = strb_q.wr;
  assign ad_addr_oe  = strb_q.addr_oe;
  assign ad_data_oe  = strb_q.data_oe;
  assign hi_addr_sel = strb_q.hi_sel;
  assign state_o     = state_of(tick_q);
  assign phase_o     = tick_q[0];
endmodule

// File: rtl/bus_strobe_seq_chk.sv
module bus_strobe_seq_chk #(
  parameter int RST_HOLD = 24
) (
  input logic       clk,
  input logic       rst_pin,
  input logic       rst_int,
  input logic       ext_q,
  input logic       dat_q,
  input logic       strap_q,
  input logic       ale_o,
  input logic       psen_o,
  input logic       rd_o,
  input logic       wr_o,
  input logic       ad_addr_oe,
  input logic       ad_data_oe,
  input logic [2:0] state_o,
  input logic       phase_o
);
  logic       armed = 1'b0;
  logic [3:0] ale_len = '0;
  logic [3:0] psen_len = '0;
  logic [3:0] rd_len = '0;
  logic [3:0] wr_len = '0;
  logic [7:0] pin_run = '0;

  always_ff @(posedge clk) begin
    armed    <= armed | rst_int;
    ale_len  <= ale_o  ? ((ale_len  == 4'hF) ? ale_len  : ale_len  + 4'd1) : 4'd0;
    psen_len <= psen_o ? ((psen_len == 4'hF) ? psen_len : psen_len + 4'd1) : 4'd0;
    rd_len   <= rd_o   ? ((rd_len   == 4'hF) ? rd_len   : rd_len   + 4'd1) : 4'd0;
    wr_len   <= wr_o   ? ((wr_len   == 4'hF) ? wr_len   : wr_len   + 4'd1) : 4'd0;
    pin_run  <= rst_pin ? ((pin_run == 8'hFF) ? pin_run : pin_run + 8'd1) : 8'd0;
  end

  p_phase_step_r1: assert property (@(posedge clk) disable iff (rst_int || !armed)
    (phase_o == 1'b0) |=> (phase_o == 1'b1) && (state_o == $past(state_o)));
  p_state_step_r1: assert property (@(posedge clk) disable iff (rst_int || !armed)
    (phase_o && state_o != 3'd6) |=> !phase_o && (state_o == $past(state_o) + 3'd1));
  p_state_wrap_r1: assert property (@(posedge clk) disable iff (rst_int || !armed)
    (phase_o && state_o == 3'd6) |=> !phase_o && (state_o == 3'd1));
  p_ale_width_r2: assert property (@(posedge clk) disable iff (rst_int || !armed)
    $fell(ale_o) |-> (ale_len == 4'd2));
  p_ale_skip_r3: assert property (@(posedge clk) disable iff (rst_int || !armed)
    (dat_q && state_o == 3'd4) |-> !ale_o);
  p_psen_width_r4: assert property (@(posedge clk) disable iff (rst_int || !armed)
    $fell(psen_o) |-> (psen_len == 4'd3));
  p_psen_data_r4: assert property (@(posedge clk) disable iff (rst_int || !armed)
    dat_q |-> !psen_o);
  p_psen_internal_r5: assert property (@(posedge clk) disable iff (rst_int || !armed)
    !ext_q |-> !psen_o);
  p_strap_hold_r6: assert property (@(posedge clk) disable iff (rst_int || !armed)
    1'b1 |=> $stable(strap_q));
  p_rd_wr_excl_r7: assert property (@(posedge clk) disable iff (rst_int || !armed)
    !(rd_o && wr_o));
  p_rd_width_r7: assert property (@(posedge clk) disable iff (rst_int || !armed)
    $fell(rd_o) |-> (rd_len == 4'd6));
  p_wr_width_r7: assert property (@(posedge clk) disable iff (rst_int || !armed)
    $fell(wr_o) |-> (wr_len == 4'd6));
  p_no_ale_in_strobe_r7: assert property (@(posedge clk) disable iff (rst_int || !armed)
    (rd_o || wr_o) |-> !ale_o);
  p_rst_filter_r9: assert property (@(posedge clk)
    (rst_pin && pin_run < 8'(RST_HOLD - 1)) |=> !rst_int);
  p_rst_quiet_r10: assert property (@(posedge clk)
    rst_int |=> !ale_o && !psen_o && !rd_o && !wr_o && !ad_addr_oe && !ad_data_oe);
  p_port_drive_r11: assert property (@(posedge clk) disable iff (rst_int || !armed)
    ad_data_oe |-> !ad_addr_oe);
  p_wr_data_r11: assert property (@(posedge clk) disable iff (rst_int || !armed)
    wr_o |-> ad_data_oe);
endmodule

bind bus_strobe_seq bus_strobe_seq_chk #(.RST_HOLD(RST_HOLD)) u_chk (
  .clk        (clk),
  .rst_pin    (rst_pin),
  .rst_int    (rst_int),
  .ext_q      (ext_q),
  .dat_q      (dat_q),
  .strap_q    (strap_q),
  .ale_o      (ale_o),
  .psen_o     (psen_o),
  .rd_o       (rd_o),
  .wr_o       (wr_o),
  .ad_addr_oe (ad_addr_oe),
  .ad_data_oe (ad_data_oe),
  .state_o    (state_o),
  .phase_o    (phase_o)
);

// File: tb/bus_strobe_seq_tb.sv
module bus_strobe_seq_tb;
  logic        clk = 1'b0;
  logic        rst_pin = 1'b1;
  logic        ea_strap = 1'b1;
  logic [15:0] pc_i = '0;
  logic        dmem_rd_req = 1'b0;
  logic        dmem_wr_req = 1'b0;
  logic        ale_o, psen_o, rd_o, wr_o, ad_addr_oe, ad_data_oe, hi_addr_sel, phase_o;
  logic [2:0]  state_o;

  int checks = 0;
  int errors = 0;
  logic strap_lat = 1'b1;
  logic prev_ale = 1'b0;
  logic prev_psen = 1'b0;

  always #10 clk = ~clk;

  bus_strobe_seq u_dut (
    .clk(clk), .rst_pin(rst_pin), .ea_strap(ea_strap), .pc_i(pc_i),
    .dmem_rd_req(dmem_rd_req), .dmem_wr_req(dmem_wr_req),
    .ale_o(ale_o), .psen_o(psen_o), .rd_o(rd_o), .wr_o(wr_o),
    .ad_addr_oe(ad_addr_oe), .ad_data_oe(ad_data_oe), .hi_addr_sel(hi_addr_sel),
    .state_o(state_o), .phase_o(phase_o)
  );

  function automatic logic [10:0] observed();
    return {ale_o, psen_o, rd_o, wr_o, ad_addr_oe, ad_data_oe, hi_addr_sel, state_o, phase_o};
  endfunction

  // expected outputs of slot t, restated from the requirements
  function automatic logic [10:0] expect_slot(input int t, input logic ext,
                                              input logic rd, input logic wr);
    logic dat, wrx, e_ale, e_psen, e_rd, e_wr, e_aoe, e_doe, e_hi;
    int half, pos;
    dat  = rd | wr;
    wrx  = wr & ~rd;
    half = t / 6;
    pos  = t % 6;
    e_ale  = (pos < 2) && !(dat && half == 1);
    e_psen = ext && !dat && (pos >= 3);
    e_rd   = rd && (t >= 3) && (t < 9);
    e_wr   = wrx && (t >= 3) && (t < 9);
    e_aoe  = e_ale && (ext || dat);
    e_doe  = wrx && (t >= 2) && (t < 10);
    e_hi   = ext || dat;
    return {e_ale, e_psen, e_rd, e_wr, e_aoe, e_doe, e_hi, 3'(t / 2 + 1), 1'(t % 2)};
  endfunction

  task automatic check_eq(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // entered at a falling edge showing slot 11; leaves at the next slot 11
  task automatic run_cycle(input logic [15:0] pc, input logic rd, input logic wr,
                           input bit midflip, input string tag);
    logic ext;
    int ale_rises = 0, psen_rises = 0, bad = 0;
    logic [10:0] exp, act;
    pc_i = pc; dmem_rd_req = rd; dmem_wr_req = wr;
    ext = !strap_lat || (pc >= 16'h1000);
    for (int t = 0; t < 12; t++) begin
      @(negedge clk);
      act = observed();
      exp = expect_slot(t, ext, rd, wr);
      if (act !== exp) begin
        bad++;
        $display("FAIL %s slot %0d actual=%b expected=%b", tag, t, act, exp);
      end
      if (ale_o && !prev_ale) ale_rises++;
      if (psen_o && !prev_psen) psen_rises++;
      prev_ale = ale_o;
      prev_psen = psen_o;
      if (midflip && t == 4) begin
        pc_i = ~pc; dmem_rd_req = ~rd; dmem_wr_req = ~wr;
      end
    end
    checks++;
    if (bad != 0) errors++;
    check_eq(32'(ale_rises), ((rd | wr) ? 32'd1 : 32'd2), {tag, " ALE pulses R2 R3"});
    check_eq(32'(psen_rises), ((ext && !(rd | wr)) ? 32'd2 : 32'd0), {tag, " PSEN pulses R4 R5"});
  endtask

  // pin high long enough, then release; ends at a falling edge showing slot 11
  task automatic do_reset(input logic strap);
    ea_strap = strap;
    rst_pin = 1'b1;
    repeat (30) @(negedge clk);
    check_eq(32'(observed()), 32'({7'b0, 3'd6, 1'b1}), "R10 outputs during reset");
    rst_pin = 1'b0;
    strap_lat = strap;
    @(negedge clk);
    check_eq(32'(observed()), 32'({7'b0, 3'd6, 1'b1}), "R10 first edge after release");
    prev_ale = 1'b0;
    prev_psen = 1'b0;
  endtask

  task automatic sweep(input string tag);
    logic [15:0] pcs [4];
    pcs[0] = 16'h0000; pcs[1] = 16'h0FFF; pcs[2] = 16'h1000; pcs[3] = 16'hFFFF;
    for (int p = 0; p < 4; p++)
      for (int k = 0; k < 4; k++)
        run_cycle(pcs[p], k[0], k[1], 1'b0, tag);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset(1'b1);                                       // R10 R9

    run_cycle(16'h0100, 1'b0, 1'b0, 1'b0, "R2 R5 internal fetch");
    run_cycle(16'h0FFF, 1'b0, 1'b0, 1'b0, "R5 last internal address");
    run_cycle(16'h1000, 1'b0, 1'b0, 1'b0, "R5 R4 boundary external");
    run_cycle(16'h2345, 1'b1, 1'b0, 1'b0, "R3 R4 R7 external read");
    run_cycle(16'h2345, 1'b0, 1'b1, 1'b0, "R3 R7 R11 external write");
    run_cycle(16'h0040, 1'b1, 1'b0, 1'b0, "R3 R11 internal read");
    run_cycle(16'h0040, 1'b0, 1'b1, 1'b0, "R11 internal write");
    run_cycle(16'h8000, 1'b1, 1'b1, 1'b0, "R7 both requests");
    run_cycle(16'h0010, 1'b0, 1'b0, 1'b1, "R8 mid-cycle change");
    run_cycle(16'h0010, 1'b0, 1'b0, 1'b0, "R8 after change");
    sweep("R11 sweep strap high");

    ea_strap = 1'b0;                                       // R6 strap moved after reset
    run_cycle(16'h0010, 1'b0, 1'b0, 1'b0, "R6 strap change ignored");

    // R9: 23 clocks high must leave the frame running
    begin
      int bad = 0;
      rst_pin = 1'b1;
      for (int i = 0; i < 23; i++) begin
        @(negedge clk);
        if ({state_o, phase_o} !== {3'(i % 12 / 2 + 1), 1'(i % 2)}) bad++;
      end
      rst_pin = 1'b0;
      @(negedge clk);
      check_eq(32'(bad), 32'd0, "R9 short pulse ignored");
      check_eq(32'({state_o, phase_o}), 32'({3'd6, 1'b1}), "R9 slot after short pulse");
    end
    run_cycle(16'h0010, 1'b0, 1'b0, 1'b0, "R9 R6 frame after short pulse");

    // R9 R10: a long pulse freezes the frame from edge 25 on
    begin
      int bad = 0;
      ea_strap = 1'b0;
      rst_pin = 1'b1;
      repeat (24) @(negedge clk);
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (observed() !== {7'b0, 3'd6, 1'b1}) bad++;
      end
      check_eq(32'(bad), 32'd0, "R9 R10 long pulse holds frame");
      rst_pin = 1'b0;
      strap_lat = 1'b0;
      @(negedge clk);
      prev_ale = 1'b0;
      prev_psen = 1'b0;
    end
    run_cycle(16'h0010, 1'b0, 1'b0, 1'b0, "R6 strap low forces external");
    ea_strap = 1'b1;
    sweep("R6 sweep strap low");
    run_cycle(16'h0000, 1'b0, 1'b0, 1'b0, "R1 R6 frame steady");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule